// File: doc/BRIEF.md
# SDRAM Command Issuer with Operation-Mode Control

This block sits between a simple host request port and an SDRAM device. It takes one access at a time and turns it into SDRAM commands. A 3-bit operation field in its configuration word decides what an access does. In normal mode the access becomes a full activate, read or write, precharge sequence. In every other mode the access issues exactly one raw SDRAM command, such as auto refresh, self-refresh entry, mode-register load, single or all-bank precharge, activate, or a bare read/write. These modes are meant for device bring-up and debug.

The block also has two extra features. A hold field inserts idle cycles after a read before the next access is accepted. A refresh timer, when enabled, raises a refresh request every programmed number of cycles. The pending refresh is served only while no access is in flight. The data path is a pass-through: write data is driven during the write command, and read data is sampled at a fixed point after the read command.

The sequencer states are:
- IDLE: ready for a request.
- RFSH: periodic refresh.
- WAKE: raises the clock-enable again after self-refresh.
- ACT, TRCD, RW, TRDP, PRE: the normal access sequence.
- ONE: the single special command.
- DONE: the completion pulse.
- HOLD: the read hold.

The transitions are:
- IDLE goes to RFSH when a refresh is pending and the clock-enable is high. Otherwise, on a request, IDLE goes to WAKE if self-refresh is active, to ACT if the mode is normal, and to ONE for any other mode.
- WAKE goes to ACT or ONE, chosen by the latched mode.
- ACT, TRCD, RW, TRDP and PRE follow one another in that order, and PRE goes to DONE.
- ONE goes to DONE.
- DONE goes to HOLD for a read in normal or raw mode when the hold setting is non-zero, and to IDLE otherwise.
- HOLD returns to IDLE when its count runs out.
- RFSH returns to IDLE.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: After reset:
  - the configuration word reads 0;
  - the command pins show NOP (cs,ras,cas,we = 0111);
  - clock-enable is high;
  - `req_ready` is 1 and `done` is 0.
- R2: The configuration word is laid out as follows. Bits [2:0] hold the operation, bit 3 enables refresh, bits [5:4] hold the read-hold code, and bits [8+PER_W-1:8] hold the refresh period. All other bits read back as 0 whatever was written.
- R3: In operation 000, an accepted access drives these commands, one per cycle:
  - ACT (0011) with the row on `sd_addr` and the bank on `sd_ba`;
  - NOP;
  - READ (0101) or WRITE (0100) with the column on `sd_addr`;
  - NOP;
  - PRE (0010) with A10=0;
  - one cycle with `done`=1.

  The request address is {bank, row, column}. `sd_dq_oe` is high only in the cycle of the write command.
- R4: For a normal read, data on `sd_dq_in` is sampled two cycles after the read command. It is returned on `rd_data` in the `done` cycle.
- R5: Operation 001 issues one REF (0001). Operation 011 issues one MRS (0000) with the low ROW_W address bits on `sd_addr`. Each is followed by one `done` cycle.
- R6: Operation 010 issues one REF with clock-enable low. Clock-enable stays low until the next access. That access begins with one NOP cycle that raises clock-enable, and only then issues its command.
- R7: The remaining single-command operations are:
  - 100: one PRE with A10=0;
  - 101: one PRE with A10=1;
  - 110: one ACT with the row;
  - 111: one READ/WRITE with the column.

  Each is followed by one `done` cycle.
- R8: After the `done` cycle of a read in operation 000 or 111, `req_ready` stays low for 0, 1, 4 or 8 idle NOP cycles for hold codes 00, 01, 10 and 11. Writes add no idle cycles.
- R9: With refresh disabled, no REF command appears unless a host access asks for one.
- R10: With refresh enabled and the port idle, a REF is issued every `period` cycles, and `req_ready` is low in the cycle before each such REF. A periodic REF never appears inside an access sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word write value |
| cfg_rdata | output | 32 | Configuration word read value |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted when high with valid |
| req_addr | input | BA_W+ROW_W+COL_W | Access address {bank, row, column} |
| req_write | input | 1 | 1 = write access |
| req_wdata | input | DW | Write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Read data, valid with `done` |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_ba | output | BA_W | SDRAM bank address |
| sd_addr | output | ROW_W | SDRAM address lines (A10 is bit 10) |
| sd_dq_out | output | DW | Data driven to SDRAM |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DW | Data returned from SDRAM |

## Verification
The bench builds the block with its default parameters:
- a 13-bit row, so the A10 bit used for all-bank precharge is a real pin;
- a 10-bit column, so column commands keep A10 clear;
- a 16-bit period field.

The refresh period is a run-time field, so the bench loads a period of 20. This places several periodic refreshes, and their exact spacing, inside a short idle window. The same short period allows an access to be started while a refresh is pending.

// File: rtl/sdci_pkg.sv
package sdci_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        OP_NORMAL   = 3'd0,
        OP_AUTOREF  = 3'd1,
        OP_SELFREF  = 3'd2,
        OP_LOADMODE = 3'd3,
        OP_PRE_ONE  = 3'd4,
        OP_PRE_ALL  = 3'd5,
        OP_ACTIVATE = 3'd6,
        OP_RAW_RW   = 3'd7
    } op_mode_e;

    typedef enum logic [3:0] {
        S_IDLE, S_RFSH, S_WAKE, S_ACT, S_TRCD, S_RW,
        S_TRDP, S_PRE, S_ONE, S_DONE, S_HOLD
    } seq_state_e;

    function automatic logic [3:0] hold_len(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 4'd0;
            2'd1:    return 4'd1;
            2'd2:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/sdci_cfg_regs.sv
module sdci_cfg_regs
    import sdci_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    output op_mode_e         op_mode,
    output logic             rfsh_en,
    output logic [1:0]       hold_sel,
    output logic [PER_W-1:0] rfsh_period,
    output logic [31:0]      cfg_rdata
);
    localparam int PER_LSB = 8;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_mode     <= OP_NORMAL;
            rfsh_en     <= 1'b0;
            hold_sel    <= 2'd0;
            rfsh_period <= '0;
        end else if (cfg_we) begin
            op_mode     <= op_mode_e'(cfg_wdata[2:0]);
            rfsh_en     <= cfg_wdata[3];
            hold_sel    <= cfg_wdata[5:4];
            rfsh_period <= cfg_wdata[PER_LSB +: PER_W];
        end
    end

    always_comb begin
        cfg_rdata                   = '0;
        cfg_rdata[2:0]              = op_mode;
        cfg_rdata[3]                = rfsh_en;
        cfg_rdata[5:4]              = hold_sel;
        cfg_rdata[PER_LSB +: PER_W] = rfsh_period;
    end

endmodule

// File: rtl/sdci_refresh_timer.sv
module sdci_refresh_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PER_W-1:0] period,
    input  logic             ack,
    output logic             pending
);
    logic [PER_W-1:0] cnt;
    logic             fire;

    assign fire = en && (({1'b0, cnt} + (PER_W+1)'(1)) >= {1'b0, period});

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            cnt <= fire ? '0 : cnt + 1'b1;
            if (fire)
                pending <= 1'b1;
            else if (ack)
                pending <= 1'b0;
        end
    end

endmodule

// File: rtl/sdci_seq.sv
module sdci_seq
    import sdci_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    parameter int DW    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  op_mode_e                  op_mode,
    input  logic [1:0]                hold_sel,
    input  logic                      rfsh_pend,
    output logic                      rfsh_ack,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [BA_W+ROW_W+COL_W-1:0] req_addr,
    input  logic                      req_write,
    input  logic [DW-1:0]             req_wdata,
    output logic                      done,
    output logic [DW-1:0]             rd_data,
    output logic                      sd_cke,
    output sd_cmd_e                   sd_cmd,
    output logic [BA_W-1:0]           sd_ba,
    output logic [ROW_W-1:0]          sd_addr,
    output logic [DW-1:0]             sd_dq_out,
    output logic                      sd_dq_oe,
    input  logic [DW-1:0]             sd_dq_in
);
    localparam int AW  = BA_W + ROW_W + COL_W;
    localparam int A10 = 10;

    seq_state_e      st, st_n;
    op_mode_e        op_q;
    logic            wr_q, cke_low, accept, hold_due;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   wdata_q, rdata_q;
    logic [3:0]      hold_cnt;
    logic [BA_W-1:0] bank_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;

    assign bank_q = addr_q[AW-1 -: BA_W];
    assign row_q  = addr_q[COL_W +: ROW_W];
    assign col_q  = addr_q[COL_W-1:0];
    assign hold_due = !wr_q && (op_q == OP_NORMAL || op_q == OP_RAW_RW)
                      && (hold_len(hold_sel) != 4'd0);

    function automatic seq_state_e entry_of(input op_mode_e m);
        return (m == OP_NORMAL) ? S_ACT : S_ONE;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n   = st;
        accept = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (rfsh_pend && !cke_low) begin
                    st_n = S_RFSH;
                end else if (req_valid) begin
                    accept = 1'b1;
                    st_n   = cke_low ? S_WAKE : entry_of(op_mode);
                end
            end
            S_RFSH: st_n = S_IDLE;
            S_WAKE: st_n = entry_of(op_q);
            S_ACT:  st_n = S_TRCD;
            S_TRCD: st_n = S_RW;
            S_RW:   st_n = S_TRDP;
            S_TRDP: st_n = S_PRE;
            S_PRE:  st_n = S_DONE;
            S_ONE:  st_n = S_DONE;
            S_DONE: st_n = hold_due ? S_HOLD : S_IDLE;
            S_HOLD: st_n = (hold_cnt == 4'd1) ? S_IDLE : S_HOLD;
            default: st_n = S_IDLE;
        endcase
    end

    // latched request, capture and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_NORMAL;
            wr_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            hold_cnt <= '0;
            cke_low  <= 1'b0;
        end else begin
            if (accept) begin
                op_q    <= op_mode;
                wr_q    <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (st == S_PRE && !wr_q) rdata_q <= sd_dq_in;
            if (st == S_DONE)         hold_cnt <= hold_len(hold_sel);
            else if (st == S_HOLD)    hold_cnt <= hold_cnt - 4'd1;
            if (st == S_ONE && op_q == OP_SELFREF) cke_low <= 1'b1;
            else if (st == S_WAKE)                 cke_low <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        sd_cmd    = CMD_NOP;
        sd_ba     = '0;
        sd_addr   = '0;
        sd_dq_oe  = 1'b0;
        sd_cke    = !cke_low;
        done      = 1'b0;
        req_ready = 1'b0;
        rfsh_ack  = 1'b0;
        unique case (st)
            S_IDLE: req_ready = !(rfsh_pend && !cke_low);
            S_RFSH: begin
                sd_cmd   = CMD_REF;
                rfsh_ack = 1'b1;
            end
            S_WAKE: sd_cke = 1'b1;
            S_ACT: begin
                sd_cmd  = CMD_ACT;
                sd_ba   = bank_q;
                sd_addr = row_q;
            end
            S_RW: begin
                sd_cmd               = wr_q ? CMD_WR : CMD_RD;
                sd_ba                = bank_q;
                sd_addr[COL_W-1:0]   = col_q;
                sd_dq_oe             = wr_q;
            end
            S_PRE: begin
                sd_cmd = CMD_PRE;
                sd_ba  = bank_q;
            end
            S_ONE: begin
                unique case (op_q)
                    OP_AUTOREF:  sd_cmd = CMD_REF;
                    OP_SELFREF: begin
                        sd_cmd = CMD_REF;
                        sd_cke = 1'b0;
                    end
                    OP_LOADMODE: begin
                        sd_cmd  = CMD_MRS;
                        sd_addr = addr_q[ROW_W-1:0];
                    end
                    OP_PRE_ONE: begin
                        sd_cmd = CMD_PRE;
                        sd_ba  = bank_q;
                    end
                    OP_PRE_ALL: begin
                        sd_cmd       = CMD_PRE;
                        sd_addr[A10] = 1'b1;
                    end
                    OP_ACTIVATE: begin
                        sd_cmd  = CMD_ACT;
                        sd_ba   = bank_q;
                        sd_addr = row_q;
                    end
                    default: begin
                        sd_cmd             = wr_q ? CMD_WR : CMD_RD;
                        sd_ba              = bank_q;
                        sd_addr[COL_W-1:0] = col_q;
                        sd_dq_oe           = wr_q;
                    end
                endcase
            end
            S_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign sd_dq_out = wdata_q;
    assign rd_data   = rdata_q;

endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
    import sdci_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    parameter int DW    = 32,
    parameter int PER_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [31:0]                 cfg_wdata,
    output logic [31:0]                 cfg_rdata,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [BA_W+ROW_W+COL_W-1:0] req_addr,
    input  logic                        req_write,
    input  logic [DW-1:0]               req_wdata,
    output logic                        done,
    output logic [DW-1:0]               rd_data,
    output logic                        sd_cke,
    output logic                        sd_cs_n,
    output logic                        sd_ras_n,
    output logic                        sd_cas_n,
    output logic                        sd_we_n,
    output logic [BA_W-1:0]             sd_ba,
    output logic [ROW_W-1:0]            sd_addr,
    output logic [DW-1:0]               sd_dq_out,
    output logic                        sd_dq_oe,
    input  logic [DW-1:0]               sd_dq_in
);
    op_mode_e         op_mode;
    logic             rfsh_en, rfsh_pend, rfsh_ack;
    logic [1:0]       hold_sel;
    logic [PER_W-1:0] rfsh_period;
    sd_cmd_e          sd_cmd;

    sdci_cfg_regs #(.PER_W(PER_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .op_mode(op_mode), .rfsh_en(rfsh_en), .hold_sel(hold_sel),
        .rfsh_period(rfsh_period), .cfg_rdata(cfg_rdata)
    );

    sdci_refresh_timer #(.PER_W(PER_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .en(rfsh_en), .period(rfsh_period),
        .ack(rfsh_ack), .pending(rfsh_pend)
    );

    sdci_seq #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .hold_sel(hold_sel),
        .rfsh_pend(rfsh_pend), .rfsh_ack(rfsh_ack),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .done(done),
        .rd_data(rd_data), .sd_cke(sd_cke), .sd_cmd(sd_cmd), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = sd_cmd;

endmodule

// File: rtl/sdci_checker.sv
module sdci_checker #(
    parameter int PER_W = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cfg_rdata,
    input logic        req_ready,
    input logic        done,
    input logic        sd_cke,
    input logic        sd_cs_n,
    input logic        sd_ras_n,
    input logic        sd_cas_n,
    input logic        sd_we_n,
    input logic        sd_dq_oe,
    input logic        rfsh_en,
    input logic        rfsh_pend
);
    localparam logic [31:0] KEEP = {{(24-PER_W){1'b0}}, {PER_W{1'b1}}, 8'h3F};

    logic [3:0] cmd;
    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // R2: bits outside the fields never read as 1
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~KEEP) == 32'd0);

    // R3: every command other than refresh is followed by a NOP cycle
    p_cmd_then_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 4'b0111 && cmd != 4'b0001) |=> (cmd == 4'b0111));

    // R3: completion is a single-cycle pulse
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: data is driven only with a write command
    p_oe_with_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (cmd == 4'b0100));

    // R6: clock-enable only falls together with the refresh command
    p_cke_fall_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_cke) |-> (cmd == 4'b0001));

    // R9: no refresh request exists while refresh is disabled
    p_no_pend_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_pend |-> rfsh_en);

    // R10: a pending refresh blocks new host requests
    p_pend_blocks_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_pend && sd_cke) |-> !req_ready);

endmodule

bind sdram_cmd_issuer sdci_checker #(.PER_W(PER_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .req_ready(req_ready),
    .done(done), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dq_oe(sd_dq_oe),
    .rfsh_en(rfsh_en), .rfsh_pend(rfsh_pend)
);

// File: tb/sim_sdram_cmd_issuer.sv
`timescale 1ns/1ps
module sim_sdram_cmd_issuer;

    localparam int BA_W = 2, ROW_W = 13, COL_W = 10, DW = 32, PER_W = 16;
    localparam int AW = BA_W + ROW_W + COL_W;
    localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                           C_NOP = 4'b0111;
    localparam logic [DW-1:0] JUNK = 32'hDEAD_BEEF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic req_valid = 1'b0, req_ready, req_write = 1'b0, done;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, rd_data, sd_dq_out, sd_dq_in;
    logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [BA_W-1:0] sd_ba;
    logic [ROW_W-1:0] sd_addr;
    logic [3:0] cmd_w;

    assign cmd_w = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    initial sd_dq_in = JUNK;
    always #2 clk = ~clk;

    sdram_cmd_issuer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .done(done), .rd_data(rd_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    int n_chk = 0, n_fail = 0;
    int m_op = 0, m_hold = 0;
    bit m_cke_low = 1'b0;

    typedef struct {
        logic [6:0]       sig;   // {ready, cke, cmd[3:0], done}
        bit               chk_a;
        logic [ROW_W-1:0] a;
        logic [BA_W-1:0]  ba;
        bit               oe;
        bit               drive;
    } step_t;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int op, input bit en, input int hold, input int per);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {8'd0, per[15:0], 2'b00, hold[1:0], en, op[2:0]};
        @(negedge clk);
        cfg_we = 1'b0;
        m_op   = op;
        m_hold = (hold == 0) ? 0 : (hold == 1) ? 1 : (hold == 2) ? 4 : 8;
    endtask

    function automatic step_t mk(input bit rdy, input bit cke, input logic [3:0] c,
                                 input bit dn);
        step_t s;
        s.sig = {rdy, cke, c, dn};
        s.chk_a = 1'b0; s.a = '0; s.ba = '0; s.oe = 1'b0; s.drive = 1'b0;
        return s;
    endfunction

    task automatic access(input logic [AW-1:0] addr, input bit wr,
                          input logic [DW-1:0] pat, input bit chk_ready, input string req);
        step_t q[$];
        step_t s;
        logic [BA_W-1:0]  bank = addr[AW-1 -: BA_W];
        logic [ROW_W-1:0] row  = addr[COL_W +: ROW_W];
        logic [ROW_W-1:0] colv = '0;
        logic [3:0]       rw   = wr ? C_WR : C_RD;
        colv[COL_W-1:0] = addr[COL_W-1:0];
        if (m_cke_low) begin
            q.push_back(mk(0, 1, C_NOP, 0));
            m_cke_low = 1'b0;
        end
        case (m_op)
            0: begin
                s = mk(0,1,C_ACT,0); s.chk_a = 1; s.a = row; s.ba = bank; q.push_back(s);
                q.push_back(mk(0,1,C_NOP,0));
                s = mk(0,1,rw,0); s.chk_a = 1; s.a = colv; s.ba = bank; s.oe = wr; q.push_back(s);
                q.push_back(mk(0,1,C_NOP,0));
                s = mk(0,1,C_PRE,0); s.chk_a = 1; s.a = '0; s.ba = bank; s.drive = !wr; q.push_back(s);
            end
            1: q.push_back(mk(0,1,C_REF,0));
            2: begin q.push_back(mk(0,0,C_REF,0)); m_cke_low = 1'b1; end
            3: begin
                s = mk(0,1,C_MRS,0); s.chk_a = 1; s.a = addr[ROW_W-1:0]; s.ba = '0; q.push_back(s);
            end
            4: begin s = mk(0,1,C_PRE,0); s.chk_a = 1; s.a = '0; s.ba = bank; q.push_back(s); end
            5: begin s = mk(0,1,C_PRE,0); s.chk_a = 1; s.a = 13'h0400; s.ba = '0; q.push_back(s); end
            6: begin s = mk(0,1,C_ACT,0); s.chk_a = 1; s.a = row; s.ba = bank; q.push_back(s); end
            default: begin
                s = mk(0,1,rw,0); s.chk_a = 1; s.a = colv; s.ba = bank; s.oe = wr; q.push_back(s);
            end
        endcase
        q.push_back(mk(0, !m_cke_low, C_NOP, 1));
        if (!wr && (m_op == 0 || m_op == 7))
            for (int k = 0; k < m_hold; k++) q.push_back(mk(0,1,C_NOP,0));

        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_write = wr; req_wdata = pat;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        foreach (q[i]) begin
            check({req_ready, sd_cke, cmd_w, done} == q[i].sig, req,
                  $sformatf("step %0d {rdy,cke,cmd,done}", i),
                  64'({req_ready, sd_cke, cmd_w, done}), 64'(q[i].sig));
            if (q[i].chk_a)
                check({sd_ba, sd_addr} == {q[i].ba, q[i].a}, req,
                      $sformatf("step %0d {ba,addr}", i),
                      64'({sd_ba, sd_addr}), 64'({q[i].ba, q[i].a}));
            if (sd_dq_oe != q[i].oe || (q[i].oe && sd_dq_out != pat))
                check(1'b0, "R3", $sformatf("step %0d write data/oe", i),
                      64'({sd_dq_oe, sd_dq_out}), 64'({q[i].oe, pat}));
            if (q[i].sig[0] && m_op == 0 && !wr)
                check(rd_data == pat, "R4", "read data on done", 64'(rd_data), 64'(pat));
            sd_dq_in = q[i].drive ? pat : JUNK;
            @(negedge clk);
            sd_dq_in = JUNK;
        end
        if (chk_ready)
            check(req_ready == 1'b1, "R8", "ready after hold", 64'(req_ready), 64'd1);
    endtask

    initial begin : watchdog
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int last, nref;
        bit prev_rdy;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cfg_rdata == 32'd0, "R1", "cfg after reset", 64'(cfg_rdata), 64'd0);
        check(cmd_w == C_NOP, "R1", "cmd after reset", 64'(cmd_w), 64'(C_NOP));
        check(sd_cke == 1'b1, "R1", "cke after reset", 64'(sd_cke), 64'd1);
        check(req_ready == 1'b1 && done == 1'b0, "R1", "ready/done after reset",
              64'({req_ready, done}), 64'b10);

        // R2 field layout and reserved bits
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
        @(negedge clk); cfg_we = 1'b0;
        check(cfg_rdata == 32'h00FF_FF3F, "R2", "all-ones readback", 64'(cfg_rdata), 64'h00FF_FF3F);
        cfg_write(0, 0, 0, 0);
        check(cfg_rdata == 32'd0, "R2", "cleared readback", 64'(cfg_rdata), 64'd0);
        cfg_write(5, 1, 2, 16'h1234);
        check(cfg_rdata == 32'h0012_342D, "R2", "field readback", 64'(cfg_rdata), 64'h0012_342D);
        cfg_write(0, 0, 0, 0);

        // R3 / R4 normal accesses, hold 0
        access({2'd2, 13'h1ABC, 10'h155}, 1'b1, 32'hA5A5_0001, 1'b1, "R3");
        access({2'd1, 13'h0F0F, 10'h2AA}, 1'b0, 32'h1234_5678, 1'b1, "R4");
        access({2'd3, 13'h1FFF, 10'h3FF}, 1'b0, 32'h0BAD_CAFE, 1'b1, "R3");

        // R8 hold settings
        for (int h = 1; h < 4; h++) begin
            cfg_write(0, 0, h, 0);
            access({2'd0, 13'h0011, 10'h022}, 1'b0, 32'h5000_0000 + h, 1'b1, "R8");
        end
        access({2'd0, 13'h0011, 10'h023}, 1'b1, 32'h7777_0000, 1'b1, "R8");

        // R5 refresh command and mode-register load
        cfg_write(1, 0, 0, 0);
        access('0, 1'b0, '0, 1'b1, "R5");
        cfg_write(3, 0, 0, 0);
        access({2'd0, 13'h0000, 10'h233}, 1'b1, '0, 1'b1, "R5");

        // R7 single-command debug operations
        cfg_write(4, 0, 0, 0);
        access({2'd3, 13'h0055, 10'h011}, 1'b0, '0, 1'b1, "R7");
        cfg_write(5, 0, 0, 0);
        access({2'd2, 13'h0055, 10'h011}, 1'b0, '0, 1'b1, "R7");
        cfg_write(6, 0, 0, 0);
        access({2'd1, 13'h1234, 10'h011}, 1'b0, '0, 1'b1, "R7");
        cfg_write(7, 0, 1, 0);
        access({2'd2, 13'h0001, 10'h3C3}, 1'b0, '0, 1'b1, "R7");
        access({2'd2, 13'h0001, 10'h0C3}, 1'b1, 32'hFEED_0007, 1'b1, "R7");

        // R6 self refresh, clock-enable held low, wake on next access
        cfg_write(2, 0, 0, 0);
        access('0, 1'b0, '0, 1'b1, "R6");
        cfg_write(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        check(sd_cke == 1'b0, "R6", "cke held low while idle", 64'(sd_cke), 64'd0);
        access({2'd1, 13'h0100, 10'h010}, 1'b0, 32'h00C0_FFEE, 1'b1, "R6");
        check(sd_cke == 1'b1, "R6", "cke after wake", 64'(sd_cke), 64'd1);

        // R9 refresh disabled: no REF on an idle port
        nref = 0;
        for (int i = 0; i < 60; i++) begin
            if (cmd_w == C_REF) nref++;
            @(negedge clk);
        end
        check(nref == 0, "R9", "REF count while disabled", 64'(nref), 64'd0);

        // R10 periodic refresh
        cfg_write(0, 1, 0, 20);
        last = -1; nref = 0; prev_rdy = 1'b1;
        for (int i = 0; i < 90; i++) begin
            if (cmd_w == C_REF) begin
                check(!prev_rdy, "R10", "ready low before REF", 64'(prev_rdy), 64'd0);
                if (last >= 0)
                    check(i - last == 20, "R10", "REF spacing", 64'(i - last), 64'd20);
                last = i; nref++;
            end
            prev_rdy = req_ready;
            @(negedge clk);
        end
        check(nref >= 4, "R10", "REF count in window", 64'(nref), 64'd4);
        repeat (12) @(negedge clk);
        access({2'd2, 13'h0777, 10'h077}, 1'b0, 32'h3141_5926, 1'b0, "R10");
        access({2'd1, 13'h0123, 10'h045}, 1'b1, 32'h2718_2818, 1'b0, "R10");
        cfg_write(0, 0, 0, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule